// File: doc/BRIEF.md
# Supply Supervisor Reset Controller

This block sequences the system reset of a microcontroller. It merges three reset causes: a low supply-good flag from an external comparator, a manual request sensed on the bidirectional active-low reset pin, and starvation of a watchdog whose input must keep toggling. All three causes feed one release timer. The two reset outputs are open-drain enables. `rst_pull_en` pulls the active-low pin to ground. `rst_drive_en` drives the active-high pin against its pull-down. All intervals are parameters counted in clock cycles. The defaults are 200 ms for the release delay and 1.6 s for the watchdog, at 125 MHz.

The controller is a three-state machine:
- `ST_HOLD`: a cause is present, or the block has just left its own reset. Reset is active.
- `ST_RELEASE`: the release timer is counting. Reset is still active.
- `ST_RUN`: reset is inactive.

The transitions are:
- `HOLD_TO_RELEASE`: no level cause (supply fault or manual press) remains.
- `RELEASE_TO_HOLD`: any cause appears.
- `RELEASE_TO_RUN`: the timer has counted `RELEASE_CYCLES`.
- `RUN_TO_HOLD`: any cause appears.

The supply flag is taken as already synchronised. The watchdog input and the pin readback each pass through a `SYNC_STAGES`-flop synchroniser, which must have at least two stages. The block knows the pin level it drives itself, so it masks the readback while it pulls the pin low and for `SYNC_STAGES` cycles after it lets go.

Top module: `supply_reset_ctrl`

## Requirements
- R1: When `supply_ok` is sampled low at a clock edge, both reset enables are active after that edge and stay active for as long as `supply_ok` stays low.
- R2: When `supply_ok` is sampled high again in `ST_HOLD` with no other cause present, the enables stay active through the next `RELEASE_CYCLES` edges and release on edge `RELEASE_CYCLES`+1.
- R3: `rst_pull_en` and `rst_drive_en` are equal in every cycle, with 1 meaning reset is active.
- R4: If the pin readback `rst_n_pin` goes low from outside while the block is not driving it, reset goes active on the third clock edge. The block then spends one cycle in `ST_HOLD` and runs the full release interval.
- R5: After a release, the block's own drive seen on the readback causes no new reset. With the pin then high, the enables stay inactive.
- R6: If the pin is still held low from outside when reset releases, reset goes active again on the third edge after the release edge.
- R7: A rising and a falling transition of `wdt_in` each restart the watchdog count.
- R8: After the last `wdt_in` transition is sampled, with no further transition, reset goes active on edge `WDT_CYCLES`+2.
- R9: A watchdog reset lasts exactly `RELEASE_CYCLES`+1 cycles. The watchdog then counts from zero and, without a kick, asserts reset again `WDT_CYCLES` edges after the release edge.
- R10: The watchdog count is held at zero while reset is active. A supply fault longer than `WDT_CYCLES` therefore leaves a full watchdog interval after release.
- R11: A new cause during the release interval returns the machine to `ST_HOLD`, and the full interval restarts when the cause is gone.
- R12: A low on `rst_n` activates both enables at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset of the sequencer, active low |
| supply_ok | input | 1 | Synchronised supply-good flag from the comparator |
| wdt_in | input | 1 | Watchdog kick input, asynchronous; either edge kicks |
| rst_n_pin | input | 1 | Level read back from the active-low reset pin |
| rst_pull_en | output | 1 | Open-drain enable pulling the active-low reset pin to ground |
| rst_drive_en | output | 1 | Open-drain enable driving the active-high reset pin |

## Verification
A wrong state or counter in this block shows up only as a reset edge in the wrong cycle. A release timer that is off by one moves the falling edge of both enables by one cycle after every cause. A watchdog count that is not cleared during reset makes a second reset appear shortly after a long supply fault instead of `WDT_CYCLES` later. A readback mask that is too short makes the block re-trigger itself within three cycles of every release. For these reasons, each release and each assertion is checked in the exact cycle where it is expected, and also in the cycle before it.

// File: rtl/supply_reset_pkg.sv
package supply_reset_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_RELEASE = 2'd1,
        ST_RUN     = 2'd2
    } sup_state_e;

endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sr_release_timer.sv
module sr_release_timer #(
    parameter int CYCLES = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (!run)  cnt_q <= '0;
        else if (!done) cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/sr_watchdog.sv
module sr_watchdog #(
    parameter int CYCLES = 200_000_000,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kick_lvl,
    input  logic          hold,
    output logic          expire,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic prev_q;
    logic kick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= kick_lvl;
    end

    assign kick   = kick_lvl ^ prev_q;
    assign expire = !hold && !kick && (count == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        count <= '0;
        else if (hold || kick || expire)   count <= '0;
        else                               count <= count + 1'b1;
    end
endmodule

// File: rtl/supply_reset_ctrl.sv
module supply_reset_ctrl
    import supply_reset_pkg::*;
#(
    parameter int RELEASE_CYCLES = 25_000_000,
    parameter int WDT_CYCLES     = 200_000_000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic wdt_in,
    input  logic rst_n_pin,
    output logic rst_pull_en,
    output logic rst_drive_en
);
    localparam int WCW = $clog2(WDT_CYCLES + 1);

    sup_state_e state_q, state_d;
    logic       reset_active;
    logic       wdt_sync, pin_sync;
    logic [SYNC_STAGES-1:0] drive_hist_q;
    logic       manual_req, supply_fault, wdt_expire;
    logic       level_cause, any_cause, rel_done;
    logic [WCW-1:0] wdt_count;

    // pin idles high, watchdog level idles low
    sr_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b10)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({rst_n_pin, wdt_in}),
        .q    ({pin_sync, wdt_sync})
    );

    sr_release_timer #(.CYCLES(RELEASE_CYCLES)) u_rel (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q == ST_RELEASE),
        .done (rel_done)
    );

    sr_watchdog #(.CYCLES(WDT_CYCLES)) u_wdt (
        .clk     (clk),
        .rst_n   (rst_n),
        .kick_lvl(wdt_sync),
        .hold    (reset_active),
        .expire  (wdt_expire),
        .count   (wdt_count)
    );

    // history of own drive covers the synchroniser latency
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drive_hist_q <= '1;
        else        drive_hist_q <= {drive_hist_q[SYNC_STAGES-2:0], reset_active};
    end

    assign supply_fault = !supply_ok;
    assign manual_req   = !pin_sync && !reset_active && !(|drive_hist_q);
    assign level_cause  = supply_fault || manual_req;
    assign any_cause    = level_cause || wdt_expire;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:    if (!level_cause) state_d = ST_RELEASE;
            ST_RELEASE: begin
                if (any_cause)     state_d = ST_HOLD;
                else if (rel_done) state_d = ST_RUN;
            end
            ST_RUN:     if (any_cause) state_d = ST_HOLD;
            default:    state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        reset_active = (state_q != ST_RUN) || !rst_n;
        rst_pull_en  = reset_active;
        rst_drive_en = reset_active;
    end
endmodule

// File: rtl/supply_reset_ctrl_chk.sv
module supply_reset_ctrl_chk #(
    parameter int WCW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           supply_ok,
    input logic           rst_pull_en,
    input logic [WCW-1:0] wdt_count
);
    // R1
    supply_low_forces_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> rst_pull_en);

    // R2
    recovery_still_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_ok) |=> rst_pull_en);

    // R2
    release_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_pull_en) |-> $past(supply_ok));

    // R9
    reset_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pull_en) |=> rst_pull_en);

    // R10
    wdt_cleared_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pull_en |=> (wdt_count == '0));
endmodule

bind supply_reset_ctrl supply_reset_ctrl_chk #(.WCW(WCW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok  (supply_ok),
    .rst_pull_en(rst_pull_en),
    .wdt_count  (wdt_count)
);

// File: tb/supply_reset_ctrl_bench.sv
module supply_reset_ctrl_bench;
    localparam int REL = 8;
    localparam int WDT = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic wdt_in = 1'b0;
    logic press = 1'b0;
    logic wd_auto = 1'b0;
    logic rst_n_pin;
    logic pull_en, drive_en;
    int   n_chk = 0;
    int   n_fail = 0;

    always #4 clk = ~clk;

    assign rst_n_pin = !(press || pull_en);

    supply_reset_ctrl #(
        .RELEASE_CYCLES(REL),
        .WDT_CYCLES    (WDT),
        .SYNC_STAGES   (2)
    ) u_supply_reset_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok   (supply_ok),
        .wdt_in      (wdt_in),
        .rst_n_pin   (rst_n_pin),
        .rst_pull_en (pull_en),
        .rst_drive_en(drive_en)
    );

    typedef struct packed {
        logic       sup;
        logic       prs;
        logic       exp;
        logic [4:0] req;
        logic [7:0] cyc;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b1, 5'd2,  8'd8},  // R2 after power-on
        '{1'b1, 1'b0, 1'b0, 5'd2,  8'd1},
        '{1'b0, 1'b0, 1'b1, 5'd1,  8'd1},  // R1 fault
        '{1'b0, 1'b0, 1'b1, 5'd1,  8'd20},
        '{1'b1, 1'b0, 1'b1, 5'd2,  8'd8},
        '{1'b1, 1'b0, 1'b0, 5'd2,  8'd1},
        '{1'b0, 1'b0, 1'b1, 5'd1,  8'd1},  // R11 restart
        '{1'b1, 1'b0, 1'b1, 5'd11, 8'd5},
        '{1'b0, 1'b0, 1'b1, 5'd11, 8'd1},
        '{1'b1, 1'b0, 1'b1, 5'd11, 8'd8},
        '{1'b1, 1'b0, 1'b0, 5'd11, 8'd1},
        '{1'b1, 1'b0, 1'b0, 5'd5,  8'd10},
        '{1'b1, 1'b1, 1'b0, 5'd4,  8'd2},  // R4 press
        '{1'b1, 1'b1, 1'b1, 5'd4,  8'd1},
        '{1'b1, 1'b1, 1'b1, 5'd4,  8'd8},
        '{1'b1, 1'b1, 1'b0, 5'd4,  8'd1},
        '{1'b1, 1'b1, 1'b0, 5'd6,  8'd2},  // R6 still held
        '{1'b1, 1'b1, 1'b1, 5'd6,  8'd1},
        '{1'b1, 1'b0, 1'b1, 5'd4,  8'd8},
        '{1'b1, 1'b0, 1'b0, 5'd4,  8'd1},
        '{1'b1, 1'b0, 1'b0, 5'd5,  8'd10}, // R5 no self trigger
        '{1'b1, 1'b0, 1'b0, 5'd5,  8'd3},
        '{1'b1, 1'b0, 1'b0, 5'd5,  8'd3},
        '{1'b1, 1'b0, 1'b0, 5'd5,  8'd3}
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input logic exp, input int req);
        n_chk++;
        if (pull_en !== exp) begin
            n_fail++;
            $display("FAIL R%0d: rst_pull_en=%b expected %b at %0t", req, pull_en, exp, $time);
        end
        n_chk++;
        if (drive_en !== pull_en) begin  // R3
            n_fail++;
            $display("FAIL R3: rst_drive_en=%b expected %b at %0t", drive_en, pull_en, $time);
        end
    endtask

    initial begin : wd_bg
        int tick = 0;
        forever begin
            @(negedge clk);
            if (wd_auto) begin
                tick++;
                if (tick % 10 == 0) wdt_in = ~wdt_in;
            end
        end
    end

    initial begin : watchdog_timer
        repeat (20000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        #1 check(1'b1, 12);      // R12 reset state
        step(3);
        check(1'b1, 12);
        rst_n = 1'b1;
        wd_auto = 1'b1;
        for (int i = 0; i < NV; i++) begin
            supply_ok = VECS[i].sup;
            press     = VECS[i].prs;
            step(int'(VECS[i].cyc));
            check(VECS[i].exp, int'(VECS[i].req));
        end

        // R8 timeout timing
        wd_auto = 1'b0;
        step(1);
        wdt_in = ~wdt_in;
        step(WDT + 2);
        check(1'b0, 8);
        step(1);
        check(1'b1, 8);
        // R9 length and restart from zero
        step(REL);
        check(1'b1, 9);
        step(1);
        check(1'b0, 9);
        step(WDT - 1);
        check(1'b0, 9);
        step(1);
        check(1'b1, 9);
        step(REL + 1);
        check(1'b0, 9);

        // R7 both edge directions kick
        wdt_in = ~wdt_in;
        step(30);
        check(1'b0, 7);
        wdt_in = ~wdt_in;
        step(WDT + 2);
        check(1'b0, 7);
        step(1);
        check(1'b1, 7);
        step(REL + 1);
        check(1'b0, 7);

        // R10 long fault leaves a full watchdog window
        supply_ok = 1'b0;
        step(3 * WDT);
        check(1'b1, 10);
        supply_ok = 1'b1;
        step(REL);
        check(1'b1, 10);
        step(1);
        check(1'b0, 10);
        step(WDT - 1);
        check(1'b0, 10);
        step(1);
        check(1'b1, 10);
        step(REL + 1);
        check(1'b0, 10);

        // R12 asynchronous entry mid-run
        rst_n = 1'b0;
        #1 check(1'b1, 12);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule